// File: doc/BRIEF.md
# Load-Use Interlock Register Scoreboard

This block keeps one busy flag per architectural register for an in-order pipeline. A load that issues marks its destination register busy. The flag stays set until the memory system returns data for that register. Each cycle the block looks at the two source indices and the destination index of the instruction that is trying to issue. It raises a stall if any of those registers is still waiting on a load.

Instructions that touch no pending register issue at once, even while a load is still outstanding. A load return clears its flag in the same cycle, so a dependent instruction presented in that cycle is released without an extra bubble. A stalled instruction changes no flag. Only an instruction that actually issues can mark its destination busy.

Top module: `lu_scoreboard`

## Requirements
- R1: After the active-low reset `rst_ni` is released, every flag is clear, and a valid instruction naming any register does not stall.
- R2: A valid, unstalled instruction with `iss_load_i` = 1 marks its destination register busy from the next cycle.
- R3: A valid instruction stalls when its first or second source index names a busy register.
- R4: A valid instruction stalls when its destination index names a busy register (write-after-write).
- R5: A valid instruction whose three indices all name non-busy registers does not stall, even while loads to other registers are outstanding.
- R6: A load return (`ret_valid_i` = 1, index `ret_idx_i`) clears that register's flag. In the same cycle the register already counts as free for the stall decision, and it stays free afterwards unless a new load sets it.
- R7: A stalled instruction sets no flag, even when it is a load.
- R8: `stall_o` is 0 whenever `iss_valid_i` is 0.
- R9: When a return and an issuing load name the same register in the same cycle, the register is busy in the next cycle.
- R10: A return that names a register that is not busy leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | An instruction is presented for issue |
| iss_src0_i | input | IDX_W | First source register index |
| iss_src1_i | input | IDX_W | Second source register index |
| iss_dst_i | input | IDX_W | Destination register index |
| iss_load_i | input | 1 | The presented instruction is a load |
| ret_valid_i | input | 1 | Memory returns data this cycle |
| ret_idx_i | input | IDX_W | Register index of the returned data |
| stall_o | output | 1 | Presented instruction must not issue this cycle |

## Verification
The hardest situation to reach is a single cycle in which a return, a dependent issue and often a new load all name the same register. This exercises the same-cycle release and the case where setting a flag wins over clearing it. Directed sequences build each of these overlaps on purpose. Random stimulus then draws indices from the 8-register space, with loads and returns frequent enough that several flags are pending at once and returns often land on the register being issued. A probe instruction that is not a load reads back a flag's state through `stall_o`.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned LU_NREGS_DEF = 8;
  localparam int unsigned LU_NPORTS    = 3;  // src0, src1, dst
endpackage

// File: rtl/lu_busy_flags.sv
module lu_busy_flags #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ret_valid_i,
  input  logic [IDX_W-1:0] ret_idx_i,
  input  logic             set_valid_i,
  input  logic [IDX_W-1:0] set_idx_i,
  output logic [NREGS-1:0] busy_q_o,
  output logic [NREGS-1:0] busy_eff_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_flag
    logic clr, set;
    assign clr = ret_valid_i && (ret_idx_i == IDX_W'(g));
    assign set = set_valid_i && (set_idx_i == IDX_W'(g));
    // return is visible in the same cycle
    assign busy_eff_o[g] = busy_q_o[g] & ~clr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) busy_q_o[g] <= 1'b0;
      else         busy_q_o[g] <= busy_eff_o[g] | set;
    end
  end
endmodule

// File: rtl/lu_hazard_check.sv
module lu_hazard_check #(
  parameter int unsigned NREGS  = 8,
  parameter int unsigned IDX_W  = $clog2(NREGS),
  parameter int unsigned NPORTS = 3
) (
  input  logic                         valid_i,
  input  logic [NREGS-1:0]             busy_i,
  input  logic [NPORTS-1:0][IDX_W-1:0] idx_i,
  output logic [NPORTS-1:0]            hit_o,
  output logic                         stall_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign hit_o[p] = busy_i[idx_i[p]];
  end
  assign stall_o = valid_i && (|hit_o);
endmodule

// File: rtl/lu_scoreboard.sv
module lu_scoreboard #(
  parameter int unsigned NREGS = lu_pkg::LU_NREGS_DEF,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_valid_i,
  input  logic [IDX_W-1:0] iss_src0_i,
  input  logic [IDX_W-1:0] iss_src1_i,
  input  logic [IDX_W-1:0] iss_dst_i,
  input  logic             iss_load_i,
  input  logic             ret_valid_i,
  input  logic [IDX_W-1:0] ret_idx_i,
  output logic             stall_o
);
  localparam int unsigned NP = lu_pkg::LU_NPORTS;

  logic [NREGS-1:0]         busy_q, busy_eff;
  logic [NP-1:0][IDX_W-1:0] chk_idx;
  logic [NP-1:0]            chk_hit;
  logic                     set_valid;

  assign chk_idx   = {iss_dst_i, iss_src1_i, iss_src0_i};
  // only an issuing load claims its destination
  assign set_valid = iss_valid_i && iss_load_i && !stall_o;

  lu_busy_flags #(.NREGS(NREGS), .IDX_W(IDX_W)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ret_valid_i (ret_valid_i),
    .ret_idx_i   (ret_idx_i),
    .set_valid_i (set_valid),
    .set_idx_i   (iss_dst_i),
    .busy_q_o    (busy_q),
    .busy_eff_o  (busy_eff)
  );

  lu_hazard_check #(.NREGS(NREGS), .IDX_W(IDX_W), .NPORTS(NP)) u_haz (
    .valid_i (iss_valid_i),
    .busy_i  (busy_eff),
    .idx_i   (chk_idx),
    .hit_o   (chk_hit),
    .stall_o (stall_o)
  );
endmodule

// File: rtl/lu_scoreboard_chk.sv
module lu_scoreboard_chk #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned IDX_W = $clog2(NREGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iss_valid_i,
  input logic [IDX_W-1:0] iss_src0_i,
  input logic [IDX_W-1:0] iss_src1_i,
  input logic [IDX_W-1:0] iss_dst_i,
  input logic             iss_load_i,
  input logic             ret_valid_i,
  input logic [IDX_W-1:0] ret_idx_i,
  input logic             stall_o,
  input logic [NREGS-1:0] busy_q
);
  assert_idle_no_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_valid_i |-> !stall_o);

  assert_load_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && iss_load_i && !stall_o) |=> busy_q[$past(iss_dst_i)]);

  assert_src_busy_stalls_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && busy_q[iss_src0_i] && !(ret_valid_i && ret_idx_i == iss_src0_i))
      |-> stall_o);

  assert_dst_busy_stalls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && busy_q[iss_dst_i] && !(ret_valid_i && ret_idx_i == iss_dst_i))
      |-> stall_o);

  assert_stall_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (busy_q[iss_src0_i] || busy_q[iss_src1_i] || busy_q[iss_dst_i]));

  assert_return_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !(iss_valid_i && iss_load_i && !stall_o && iss_dst_i == ret_idx_i))
      |=> !busy_q[$past(ret_idx_i)]);

  assert_stall_no_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ($countones(busy_q) <= $past($countones(busy_q))));
endmodule

bind lu_scoreboard lu_scoreboard_chk #(.NREGS(NREGS), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_src0_i  (iss_src0_i),
  .iss_src1_i  (iss_src1_i),
  .iss_dst_i   (iss_dst_i),
  .iss_load_i  (iss_load_i),
  .ret_valid_i (ret_valid_i),
  .ret_idx_i   (ret_idx_i),
  .stall_o     (stall_o),
  .busy_q      (busy_q)
);

// File: tb/tb_lu_scoreboard.sv
`timescale 1ns/1ps
module tb_lu_scoreboard;
  localparam int NREGS = 8;
  localparam int IDX_W = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic iss_valid_i = 0, iss_load_i = 0, ret_valid_i = 0;
  logic [IDX_W-1:0] iss_src0_i = 0, iss_src1_i = 0, iss_dst_i = 0, ret_idx_i = 0;
  logic stall_o;

  int n_cmp = 0, n_bad = 0;
  logic [NREGS-1:0] m_busy = '0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  lu_scoreboard dut (.*);

  function automatic logic exp_stall(logic v, logic [IDX_W-1:0] s0, s1, d,
                                     logic rv, logic [IDX_W-1:0] ri, logic [NREGS-1:0] b);
    logic [NREGS-1:0] e = b;
    if (rv) e[ri] = 1'b0;
    return v && (e[s0] || e[s1] || e[d]);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: stall_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, advance model at posedge
  task automatic step(string req, logic v, int s0, int s1, int d, logic ld,
                      logic rv, int ri, int exp_fixed);
    logic e;
    @(negedge clk_i);
    iss_valid_i = v; iss_src0_i = IDX_W'(s0); iss_src1_i = IDX_W'(s1);
    iss_dst_i = IDX_W'(d); iss_load_i = ld; ret_valid_i = rv; ret_idx_i = IDX_W'(ri);
    #1;
    e = exp_stall(v, IDX_W'(s0), IDX_W'(s1), IDX_W'(d), rv, IDX_W'(ri), m_busy);
    if (exp_fixed >= 0 && e !== exp_fixed[0]) begin
      n_bad++;
      $display("FAIL %s: model expectation %0b differs from requirement %0d", req, e, exp_fixed);
    end
    check(req, stall_o, e);
    @(posedge clk_i);
    if (rv) m_busy[ri] = 1'b0;
    if (v && !e && ld) m_busy[d] = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1d2c;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: every register free after reset
    for (int r = 0; r < NREGS; r++) step("R1", 1, r, r, r, 0, 0, 0, 0);
    // R2: load to r3 sets busy
    step("R2", 1, 0, 1, 3, 1, 0, 0, 0);
    step("R3", 1, 3, 0, 5, 0, 0, 0, 1);
    step("R3", 1, 1, 3, 5, 0, 0, 0, 1);
    step("R4", 1, 1, 2, 3, 0, 0, 0, 1);
    step("R5", 1, 4, 5, 6, 0, 0, 0, 0);
    // R7: stalled load to r6 must not mark r6
    step("R7", 1, 3, 0, 6, 1, 0, 0, 1);
    step("R7", 1, 6, 6, 6, 0, 0, 0, 0);
    // R8: no valid, no stall
    step("R8", 0, 3, 3, 3, 0, 0, 0, 0);
    // R6: same-cycle release, then stays free
    step("R6", 1, 3, 3, 0, 0, 1, 3, 0);
    step("R6", 1, 3, 0, 0, 0, 0, 0, 0);
    // R9: load r2, then return r2 with new load r2
    step("R9", 1, 0, 0, 2, 1, 0, 0, 0);
    step("R9", 1, 0, 0, 2, 1, 1, 2, 0);
    step("R9", 1, 2, 0, 0, 0, 0, 0, 1);
    // R10: return of a free register leaves r2 busy
    step("R10", 1, 0, 0, 0, 0, 1, 7, 0);
    step("R10", 1, 2, 0, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 1, 2, 0);
    step("R1", 1, 2, 2, 2, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic v = ($urandom % 8) != 0;
      logic ld = ($urandom % 3) == 0;
      logic rv = ($urandom % 3) == 0;
      int s0 = $urandom % NREGS, s1 = $urandom % NREGS, d = $urandom % NREGS;
      int ri = ($urandom % 2) ? s0 : ($urandom % NREGS);
      string tag;
      if (!v) tag = "R8";
      else if (rv && m_busy[ri] && (ri == s0 || ri == s1 || ri == d)) tag = "R6";
      else if (m_busy[s0] || m_busy[s1]) tag = "R3";
      else if (m_busy[d]) tag = "R4";
      else if (ld) tag = "R2";
      else tag = "R5";
      step(tag, v, s0, s1, d, ld, rv, ri, -1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule